// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset Realignment

This block carries data words from a write clock domain to an unrelated read clock domain. Each side keeps its pointer in binary and in Gray form. The Gray pointer crosses to the other side through a two-flop synchronizer. Full is computed on the write side and empty on the read side, each from the synchronized copy of the opposite pointer. The read port shows the head entry on its data output while empty is low, and a read pops that entry.

The two resets behave differently so that the FIFO never delivers data out of order. A write-side reset empties the FIFO. The same event clears the read pointer and is then released into the read clock through a reset synchronizer. Empty stays asserted until that release completes. The write side then holds full until the release has travelled back into its own clock, so no word can be written while the read side is still being realigned. A read-side reset alone leaves the read pointer where it is and only forces empty while it is asserted. Words consumed before that reset are never delivered again. Applying both resets together, as at power-up, leaves the FIFO empty.

Top module: `dual_clock_fifo`

## Requirements
- R1: After both resets are applied together and released, empty reads 1 and full reads 1. Within 8 write-clock cycles of the release, full drops to 0 and empty stays 1.
- R2: Words leave the read port in the order they were accepted, across any number of pointer wrap-arounds and under any mix of simultaneous writes and reads.
- R3: Full rises once DEPTH words (4 by default) are held. A write presented while full is ignored: no word is stored and no pointer moves.
- R4: A read presented while empty is ignored. The next word written is still the first word read.
- R5: With both clocks at the same frequency and phase, a word written at write edge k into an empty FIFO drives empty low after read edge k+3. Empty is still high after edges k, k+1 and k+2.
- R6: While the read-side reset is asserted, empty reads 1 and reads are ignored. After release, reading resumes at the first word not yet consumed, and no consumed word is output again.
- R7: A write-side reset empties the FIFO. Empty stays 1 during the reset and while its release is still propagating into the read clock. The first word written afterwards is the first word read.
- R8: After a write-side reset, full stays 1 until the read side has left realignment and that fact has been synchronized back into the write clock.
- R9: With equal clocks, a read at edge k from a full FIFO drives full low after write edge k+3. Full is still high after edges k, k+1 and k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| wrst_ni | input | 1 | Write-side asynchronous reset, active low; empties the FIFO |
| wvalid_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Word to write |
| wfull_o | output | 1 | FIFO full, or write side not yet released from realignment |
| rclk_i | input | 1 | Read clock |
| rrst_ni | input | 1 | Read-side asynchronous reset, active low; keeps the read pointer |
| rready_i | input | 1 | Read request; pops the head word when empty is low |
| rdata_o | output | DATA_W | Head word, valid while empty is low |
| rempty_o | output | 1 | FIFO empty, or read side in reset or realignment |

## Verification
The bench targets these cases:

- **Reset asymmetry.** A read-side reset is applied after part of the contents has been consumed. A design that cleared the read pointer on it would replay the consumed words. A write-side reset is applied while words are still held. A design that skipped the realignment would then return stale words, or would accept a write before the read side was ready.
- **Exact cycle counts.** The bench checks the exact cycle counts of the empty and full paths. An extra or missing synchronizer stage shifts these edges and is caught.
- **Overrun and underrun.** Writes into a full FIFO and reads from an empty one are exercised. A design that moved a pointer on these would corrupt the stored order.
- **Streaming sweep.** Several write/read duty patterns run through repeated wrap-arounds. A wrong Gray compare or a wrong full test shows up there as lost or duplicated words.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int   W       = 1,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_BIT}};
      q_o    <= {W{RST_BIT}};
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side import dcfifo_pkg::*; #(
  parameter int ADDR_W = 2
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wvalid_i,
  input  logic              busy_i,
  input  logic [ADDR_W:0]   rgray_sync_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W:0]   wgray_o,
  output logic              wfull_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin_q, wbin_nxt, wgray_nxt, full_cmp;

  assign wr_en_o   = wvalid_i & ~wfull_o;
  assign wbin_nxt  = wbin_q + PW'(wr_en_o);
  assign wgray_nxt = PW'(bin_to_gray(32'(wbin_nxt)));
  // full: top two Gray bits inverted, rest equal
  assign full_cmp  = {~rgray_sync_i[PW-1:PW-2], rgray_sync_i[PW-3:0]};
  assign waddr_o   = wbin_q[ADDR_W-1:0];

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
      wfull_o <= 1'b1;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_o <= wgray_nxt;
      wfull_o <= busy_i | (wgray_nxt == full_cmp);
    end
  end

  logic [PW-1:0] rq_bin;
  assign rq_bin = PW'(gray_to_bin(32'(rgray_sync_i)));

  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (PW'(wbin_q - rq_bin) <= PW'(DEPTH)));

  assert_busy_blocks_write_R8: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    busy_i |-> (wbin_q == '0));

  assert_wgray_step_R2: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    $onehot0(wgray_o ^ $past(wgray_o)));
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side import dcfifo_pkg::*; #(
  parameter int ADDR_W = 2
) (
  input  logic              rclk_i,
  input  logic              wrst_ni,
  input  logic              rrst_ni,
  input  logic              hold_i,
  input  logic              rready_i,
  input  logic [ADDR_W:0]   wgray_sync_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rgray_o,
  output logic              rempty_o
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rbin_q, rbin_nxt, rgray_nxt;
  logic          rd_en, arst_n;

  assign arst_n    = wrst_ni & rrst_ni;
  assign rd_en     = rready_i & ~rempty_o;
  assign rbin_nxt  = rbin_q + PW'(rd_en);
  assign rgray_nxt = PW'(bin_to_gray(32'(rbin_nxt)));
  assign raddr_o   = rbin_q[ADDR_W-1:0];

  // pointer follows the write-side reset only; read reset leaves it alone
  always_ff @(posedge rclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
    end else if (hold_i) begin
      rbin_q  <= '0;
      rgray_o <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_o <= rgray_nxt;
    end
  end

  always_ff @(posedge rclk_i or negedge arst_n) begin
    if (!arst_n)     rempty_o <= 1'b1;
    else if (hold_i) rempty_o <= 1'b1;
    else             rempty_o <= (rgray_nxt == wgray_sync_i);
  end

  logic [PW-1:0] wq_bin;
  assign wq_bin = PW'(gray_to_bin(32'(wgray_sync_i)));

  assert_no_underflow_R4: assert property (@(posedge rclk_i) disable iff (!arst_n)
    !rempty_o |-> (wq_bin != rbin_q));

  assert_keep_rptr_R6: assert property (@(posedge rclk_i) disable iff (!wrst_ni || hold_i)
    !rrst_ni |=> $stable(rbin_q));

  assert_realign_R7: assert property (@(posedge rclk_i) disable iff (!wrst_ni)
    hold_i |-> (rbin_q == '0));

  assert_rgray_step_R2: assert property (@(posedge rclk_i) disable iff (!wrst_ni)
    $onehot0(rgray_o ^ $past(rgray_o)));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2   // at least 2
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wvalid_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wfull_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              rready_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rempty_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic              wr_en, r_hold, w_busy;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_sync, rgray_sync;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (wr_en) mem[waddr] <= wdata_i;
  end
  assign rdata_o = mem[raddr];

  dcfifo_sync #(.W(PW), .RST_BIT(1'b0)) u_wptr_sync (
    .clk_i(rclk_i), .rst_ni(wrst_ni), .d_i(wgray), .q_o(wgray_sync));

  dcfifo_sync #(.W(PW), .RST_BIT(1'b0)) u_rptr_sync (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(rgray), .q_o(rgray_sync));

  // write reset asserts at once, releases through rclk
  dcfifo_sync #(.W(1), .RST_BIT(1'b1)) u_hold_sync (
    .clk_i(rclk_i), .rst_ni(wrst_ni), .d_i(1'b0), .q_o(r_hold));

  // read-side release acknowledged back into wclk
  dcfifo_sync #(.W(1), .RST_BIT(1'b1)) u_busy_sync (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(r_hold), .q_o(w_busy));

  dcfifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .wclk_i      (wclk_i),
    .wrst_ni     (wrst_ni),
    .wvalid_i    (wvalid_i),
    .busy_i      (w_busy),
    .rgray_sync_i(rgray_sync),
    .wr_en_o     (wr_en),
    .waddr_o     (waddr),
    .wgray_o     (wgray),
    .wfull_o     (wfull_o)
  );

  dcfifo_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .rclk_i      (rclk_i),
    .wrst_ni     (wrst_ni),
    .rrst_ni     (rrst_ni),
    .hold_i      (r_hold),
    .rready_i    (rready_i),
    .wgray_sync_i(wgray_sync),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .rempty_o    (rempty_o)
  );
endmodule

// File: tb/test_dual_clock_fifo.sv
module test_dual_clock_fifo;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       wrst_n = 1'b0, rrst_n = 1'b0;
  logic       wvalid = 1'b0, rready = 1'b0;
  logic [7:0] wdata = '0;
  logic       wfull, rempty;
  logic [7:0] rdata;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;
  int         q[$];

  always #10 clk = ~clk;

  dual_clock_fifo #(.DATA_W(8), .ADDR_W(2)) i_dual_clock_fifo (
    .wclk_i(clk), .wrst_ni(wrst_n), .wvalid_i(wvalid), .wdata_i(wdata), .wfull_o(wfull),
    .rclk_i(clk), .rrst_ni(rrst_n), .rready_i(rready), .rdata_o(rdata), .rempty_o(rempty));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs driven at negedge; model updated from the values seen before the edge
  task automatic step(input logic wv, input logic [7:0] wd, input logic rr);
    bit aw, ar;
    wvalid = wv; wdata = wd; rready = rr;
    aw = wv && !wfull;
    ar = rr && !rempty;
    if (ar) begin
      chk("R4", (q.size() > 0) ? 1 : 0, 1);
      if (q.size() > 0) chk("R2", int'(rdata), q[0]);
    end
    @(posedge clk);
    if (ar && q.size() > 0) void'(q.pop_front());
    if (aw) q.push_back(int'(wd));
    @(negedge clk);
    wvalid = 1'b0; rready = 1'b0;
    chk("R3", (q.size() <= DEPTH) ? 1 : 0, 1);
    if (q.size() == 0) chk("R4", int'(rempty), 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(rempty), 1);
    wrst_n = 1'b1; rrst_n = 1'b1;
    chk("R1", int'(wfull), 1);
    idle(8);
    chk("R1", int'(wfull), 0);
    chk("R1", int'(rempty), 1);

    // R5: write-to-readable latency
    step(1'b1, 8'h41, 1'b0);            // edge k
    chk("R5", int'(rempty), 1);
    idle(1); chk("R5", int'(rempty), 1);
    idle(1); chk("R5", int'(rempty), 1);
    idle(1); chk("R5", int'(rempty), 0);
    chk("R5", int'(rdata), 'h41);
    step(1'b0, 8'h00, 1'b1);
    idle(4);

    // R4: reads while empty ignored
    step(1'b0, 8'h00, 1'b1); step(1'b0, 8'h00, 1'b1); step(1'b0, 8'h00, 1'b1);
    step(1'b1, 8'h77, 1'b0);
    idle(4);
    chk("R4", int'(rdata), 'h77);
    step(1'b0, 8'h00, 1'b1);
    idle(4);

    // R3 / R9: fill, overrun, full release latency
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h20 + i), 1'b0);
    chk("R3", int'(wfull), 1);
    step(1'b1, 8'hEE, 1'b0); step(1'b1, 8'hEE, 1'b0);
    chk("R3", int'(wfull), 1);
    chk("R3", q.size(), DEPTH);
    step(1'b0, 8'h00, 1'b1);            // edge k
    chk("R9", int'(wfull), 1);
    idle(1); chk("R9", int'(wfull), 1);
    idle(1); chk("R9", int'(wfull), 1);
    idle(1); chk("R9", int'(wfull), 0);
    for (int i = 0; i < DEPTH - 1; i++) step(1'b0, 8'h00, 1'b1);
    idle(4);
    chk("R3", int'(rempty), 1);
    chk("R3", q.size(), 0);

    // R2: streaming sweeps with wrap-around
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 60; i++)
        step(((i * (p + 1)) % 3) != 0, 8'((p * 60 + i) & 255), ((i + p) % (p + 2)) != 0);
      for (int i = 0; i < 14; i++) step(1'b0, 8'h00, 1'b1);
      idle(4);
      chk("R2", q.size(), 0);
      chk("R2", int'(rempty), 1);
    end

    // R6: read-side reset keeps read pointer
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h10 + i), 1'b0);
    idle(4);
    step(1'b0, 8'h00, 1'b1); step(1'b0, 8'h00, 1'b1);
    rrst_n = 1'b0;
    #1 chk("R6", int'(rempty), 1);
    step(1'b0, 8'h00, 1'b1); step(1'b0, 8'h00, 1'b1);
    chk("R6", int'(rempty), 1);
    rrst_n = 1'b1;
    idle(2);
    chk("R6", int'(rempty), 0);
    chk("R6", int'(rdata), 'h12);
    step(1'b0, 8'h00, 1'b1); step(1'b0, 8'h00, 1'b1);
    idle(4);
    chk("R6", int'(rempty), 1);
    chk("R6", q.size(), 0);

    // R7 / R8: write-side reset empties and realigns
    for (int i = 0; i < 3; i++) step(1'b1, 8'(8'h30 + i), 1'b0);
    idle(4);
    step(1'b0, 8'h00, 1'b1);
    wrst_n = 1'b0;
    #1 chk("R7", int'(rempty), 1);
    chk("R8", int'(wfull), 1);
    q.delete();
    step(1'b1, 8'h99, 1'b1); step(1'b1, 8'h99, 1'b1);
    wrst_n = 1'b1;
    chk("R7", int'(rempty), 1);
    chk("R8", int'(wfull), 1);
    step(1'b1, 8'h99, 1'b1);
    chk("R7", int'(rempty), 1);
    chk("R8", int'(wfull), 1);
    chk("R8", q.size(), 0);
    idle(8);
    chk("R8", int'(wfull), 0);
    chk("R7", int'(rempty), 1);
    step(1'b1, 8'h5A, 1'b0);
    idle(4);
    chk("R7", int'(rempty), 0);
    chk("R7", int'(rdata), 'h5A);
    step(1'b0, 8'h00, 1'b1);
    idle(4);
    chk("R7", int'(rempty), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule